// File: doc/BRIEF.md
# Inbound Message and Doorbell Interrupt Unit

This block gathers interrupt events that a remote bus master raises toward a local processor core. It handles three event sources. The first two are writes by the remote master to message slot 0 and to message slot 1. The third is a doorbell word that is 31 bits wide by default. The remote side sets doorbell bits by writing ones, and the local core clears them by writing ones.

The local core sees three registers through a plain register port: a status word, a mask word and the doorbell word. The block drives one level-sensitive interrupt line, `irq_o`, which is high while any status bit is set. A status bit can only become set while its mask bit is clear. Setting a mask bit later does not clear a status bit that is already set.

The remote inputs are single-cycle strobes. The block takes every strobe in the cycle it arrives and applies no back-pressure, so the ports have no ready signal. Register reads are combinational from `reg_addr`. Register writes take effect at the next rising clock edge. Every event in a cycle is judged against the mask value held before that edge.

Top module: `imsg_irq_unit`

## Requirements
- R1: After reset, the status, mask and doorbell registers all read 0 and `irq_o` is 0.
- R2: The register address selects the register: 0 is status, 1 is mask, 2 is doorbell, and 3 reads 0 and ignores writes. Status uses bit 0 for message 0, bit 1 for message 1 and bit 3 for the doorbell. Mask uses bits 0, 1 and 3 in the same positions. Doorbell uses bits DB_W-1..0. Status bit 2 and every unused upper bit read 0 and ignore writes.
- R3: A strobe on `rmt_msg_wr[i]` sets status bit i at the next edge, but only if mask bit i was clear before that edge.
- R4: Message status bits are write-1-to-clear through address 0. Writing 0 to them has no effect.
- R5: If a message strobe and a local write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A one on `rmt_db_set` sets the matching doorbell bit. A one written through address 2 clears it. When both act on the same bit in the same cycle, the bit ends up set.
- R7: Status bit 3 becomes set at the edge where the doorbell is, or becomes, nonzero while mask bit 3 is clear. Writes to status bit 3 have no effect.
- R8: Status bit 3 clears at the edge where the doorbell register becomes all zero.
- R9: Setting a mask bit does not clear a status bit that is already set. It only blocks later setting of that bit.
- R10: `irq_o` is a registered OR of the status bits and follows them one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Local register write strobe |
| reg_addr | input | 2 | Local register select |
| reg_wdata | input | REG_W | Local write data |
| reg_rdata | output | REG_W | Local read data, combinational from `reg_addr` |
| rmt_msg_wr | input | 2 | Remote write strobes, one per message slot |
| rmt_db_set | input | DB_W | Remote doorbell write-1-to-set bits |
| irq_o | output | 1 | Level interrupt to the local core |

## Verification
The bench builds the block with its default sizes: a 32-bit register word and a 31-bit doorbell. With these sizes the top doorbell bit and the unused bit 31 of the doorbell word can both be driven. The bench can therefore show that a local write of all ones leaves bit 31 at 0 and that the highest doorbell bit behaves like the lowest. The same build also reaches the same-cycle collision cases and the one-cycle lag between a status change and `irq_o`.

// File: rtl/imsg_pkg.sv
`timescale 1ns/1ps
package imsg_pkg;
  localparam int NUM_MSG   = 2;
  localparam int ST_W      = 4;
  localparam int ST_DB_BIT = 3;
  localparam logic [ST_W-1:0] ST_LIVE = 4'b1011;

  typedef enum logic [1:0] {
    SEL_STATUS   = 2'd0,
    SEL_MASK     = 2'd1,
    SEL_DOORBELL = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/imsg_msg_flag.sv
`timescale 1ns/1ps
module imsg_msg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mask,
  input  logic clr,
  output logic flag_q
);
  logic set_now;

  // The event wins over a clear in the same cycle.
  assign set_now = evt & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_now | (flag_q & ~clr);
  end
endmodule

// File: rtl/imsg_doorbell.sv
`timescale 1ns/1ps
module imsg_doorbell #(
  parameter int DB_W = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] rmt_set,
  input  logic [DB_W-1:0] loc_clr,
  input  logic            mask_db,
  output logic [DB_W-1:0] db_q,
  output logic            db_flag_q
);
  logic [DB_W-1:0] db_next;
  logic            any_next;

  // A remote set beats a local clear on the same bit.
  assign db_next  = (db_q & ~loc_clr) | rmt_set;
  assign any_next = |db_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q      <= '0;
      db_flag_q <= 1'b0;
    end else begin
      db_q      <= db_next;
      db_flag_q <= any_next & (db_flag_q | ~mask_db);
    end
  end
endmodule

// File: rtl/imsg_regif.sv
`timescale 1ns/1ps
module imsg_regif
  import imsg_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DB_W  = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [ST_W-1:0]     stat_vec,
  input  logic [DB_W-1:0]     db_q,
  output logic [ST_W-1:0]     mask_q,
  output logic [NUM_MSG-1:0]  st_clr,
  output logic [DB_W-1:0]     db_clr,
  output logic [REG_W-1:0]    rdata
);
  reg_sel_e sel;
  logic     wr_st, wr_mask, wr_db;

  assign sel     = reg_sel_e'(addr);
  assign wr_st   = wr_en && (sel == SEL_STATUS);
  assign wr_mask = wr_en && (sel == SEL_MASK);
  assign wr_db   = wr_en && (sel == SEL_DOORBELL);

  assign st_clr = wr_st ? wdata[NUM_MSG-1:0] : '0;
  assign db_clr = wr_db ? wdata[DB_W-1:0]    : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[ST_W-1:0] & ST_LIVE;
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_STATUS:   rdata[ST_W-1:0] = stat_vec & ST_LIVE;
      SEL_MASK:     rdata[ST_W-1:0] = mask_q;
      SEL_DOORBELL: rdata[DB_W-1:0] = db_q;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/imsg_irq_unit.sv
`timescale 1ns/1ps
module imsg_irq_unit
  import imsg_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DB_W  = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_MSG-1:0] rmt_msg_wr,
  input  logic [DB_W-1:0]    rmt_db_set,
  output logic               irq_o
);
  logic [ST_W-1:0]    stat_vec;
  logic [ST_W-1:0]    mask_q;
  logic [NUM_MSG-1:0] st_clr;
  logic [NUM_MSG-1:0] msg_flag;
  logic [DB_W-1:0]    db_clr;
  logic [DB_W-1:0]    db_q;
  logic               db_flag;

  imsg_regif #(.REG_W(REG_W), .DB_W(DB_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat_vec (stat_vec),
    .db_q     (db_q),
    .mask_q   (mask_q),
    .st_clr   (st_clr),
    .db_clr   (db_clr),
    .rdata    (reg_rdata)
  );

  for (genvar gi = 0; gi < NUM_MSG; gi++) begin : g_msg
    imsg_msg_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (rmt_msg_wr[gi]),
      .mask   (mask_q[gi]),
      .clr    (st_clr[gi]),
      .flag_q (msg_flag[gi])
    );
  end

  imsg_doorbell #(.DB_W(DB_W)) u_db (
    .clk       (clk),
    .rst_n     (rst_n),
    .rmt_set   (rmt_db_set),
    .loc_clr   (db_clr),
    .mask_db   (mask_q[ST_DB_BIT]),
    .db_q      (db_q),
    .db_flag_q (db_flag)
  );

  assign stat_vec = {db_flag, 1'b0, msg_flag};

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |stat_vec;
  end
endmodule

// File: rtl/imsg_irq_sva.sv
`timescale 1ns/1ps
module imsg_irq_sva #(
  parameter int REG_W = 32,
  parameter int DB_W  = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [1:0]       rmt_msg_wr,
  input logic [DB_W-1:0]  rmt_db_set,
  input logic             irq_o,
  input logic [3:0]       stat_vec,
  input logic [3:0]       mask_q,
  input logic [DB_W-1:0]  db_q
);
  p_irq_lags_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|stat_vec));

  p_masked_msg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_msg_wr[0] && mask_q[0] && !stat_vec[0] |=> !stat_vec[0]);

  p_masked_msg1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_msg_wr[1] && mask_q[1] && !stat_vec[1] |=> !stat_vec[1]);

  p_msg0_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_msg_wr[0] && !mask_q[0] |=> stat_vec[0]);

  p_msg1_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_msg_wr[1] && !mask_q[1] |=> stat_vec[1]);

  p_db_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_db_set[0] |=> db_q[0]);

  p_db_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q == '0) |-> !stat_vec[3]);

  p_mask_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vec[0] && !(reg_wr_en && reg_addr == 2'd0 && reg_wdata[0]) |=> stat_vec[0]);

  p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind imsg_irq_unit imsg_irq_sva #(.REG_W(REG_W), .DB_W(DB_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .rmt_msg_wr (rmt_msg_wr),
  .rmt_db_set (rmt_db_set),
  .irq_o      (irq_o),
  .stat_vec   (stat_vec),
  .mask_q     (mask_q),
  .db_q       (db_q)
);

// File: tb/test_imsg_irq_unit.sv
`timescale 1ns/1ps
module test_imsg_irq_unit;
  localparam int REG_W = 32;
  localparam int DB_W  = 31;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic [1:0]       rmt_msg_wr = '0;
  logic [DB_W-1:0]  rmt_db_set = '0;
  logic             irq_o;

  int total = 0;
  int bad = 0;

  imsg_irq_unit #(.REG_W(REG_W), .DB_W(DB_W)) i_imsg_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rmt_msg_wr(rmt_msg_wr),
    .rmt_db_set(rmt_db_set), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status", d, 0);
    rd(2'd1, d); chk("R1 mask", d, 0);
    rd(2'd2, d); chk("R1 doorbell", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 mask live bits", d, 32'h0000_000B);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R2 spare address", d, 0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R7 status not writable", d, 0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R2 doorbell stays empty", d, 0);
  endtask

  task automatic t_msg();
    logic [31:0] d;
    rmt_msg_wr = 2'b01; tick(); rmt_msg_wr = 2'b00;
    rd(2'd0, d); chk("R3 msg0 sets", d, 32'h1);
    chk("R10 irq lags", {31'b0, irq_o}, 0);
    tick();
    chk("R10 irq high", {31'b0, irq_o}, 1);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R4 zero write keeps", d, 32'h1);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R4 w1c clears", d, 0);
    chk("R10 irq still high", {31'b0, irq_o}, 1);
    tick();
    chk("R10 irq low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd1, 32'h2);
    rmt_msg_wr = 2'b10; tick(); rmt_msg_wr = 2'b00;
    rd(2'd0, d); chk("R3 masked msg1", d, 0);
    tick();
    chk("R3 masked no irq", {31'b0, irq_o}, 0);
    wr(2'd1, 32'h0);
    rmt_msg_wr = 2'b10; tick(); rmt_msg_wr = 2'b00;
    rd(2'd0, d); chk("R3 msg1 sets", d, 32'h2);
    wr(2'd0, 32'h2);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    rmt_msg_wr = 2'b10;
    wr(2'd0, 32'h2);
    rmt_msg_wr = 2'b00;
    rd(2'd0, d); chk("R5 event beats clear", d, 32'h2);
    wr(2'd0, 32'h2);
    rd(2'd0, d); chk("R5 later clear", d, 0);
  endtask

  task automatic t_mask_keep();
    logic [31:0] d;
    rmt_msg_wr = 2'b01; tick(); rmt_msg_wr = 2'b00;
    wr(2'd1, 32'h1);
    tick();
    rd(2'd0, d); chk("R9 mask keeps status", d, 32'h1);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0);
    tick();
  endtask

  task automatic t_db();
    logic [31:0] d;
    rmt_db_set = 31'h4000_0001; tick(); rmt_db_set = '0;
    rd(2'd2, d); chk("R6 doorbell set", d, 32'h4000_0001);
    rd(2'd0, d); chk("R7 db status same edge", d, 32'h8);
    wr(2'd2, 32'h1);
    rd(2'd2, d); chk("R6 local clear", d, 32'h4000_0000);
    rd(2'd0, d); chk("R8 status held nonzero", d, 32'h8);
    rmt_db_set = 31'h20;
    wr(2'd2, 32'h20);
    rmt_db_set = '0;
    rd(2'd2, d); chk("R6 set beats clear", d, 32'h4000_0020);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R6 cleared, bit31 zero", d, 0);
    rd(2'd0, d); chk("R8 db status cleared", d, 0);
    chk("R10 irq before drop", {31'b0, irq_o}, 1);
    tick();
    chk("R10 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_db_mask();
    logic [31:0] d;
    wr(2'd1, 32'h8);
    rmt_db_set = 31'h3; tick(); rmt_db_set = '0;
    rd(2'd0, d); chk("R7 masked db", d, 0);
    wr(2'd1, 32'h0);
    tick();
    rd(2'd0, d); chk("R7 unmask sets", d, 32'h8);
    wr(2'd1, 32'h8);
    tick();
    rd(2'd0, d); chk("R9 db mask keeps", d, 32'h8);
    wr(2'd2, 32'h3);
    rd(2'd0, d); chk("R8 clear under mask", d, 0);
    wr(2'd1, 32'h0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_map();
    t_msg();
    t_mask();
    t_collide();
    t_mask_keep();
    t_db();
    t_db_mask();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule